// File: doc/BRIEF.md
# Packed BCD Byte Adder/Subtractor

This unit adds or subtracts two-digit packed decimal values held in the lowest byte of two operands. An extend flag supplies the decimal carry for an add or the borrow for a subtract, so several bytes can be chained from the least to the most significant byte. Each digit is corrected separately against fixed thresholds. The result replaces only the lowest byte of the destination, and the upper bits pass through unchanged. The unit also produces new extend, carry, zero, negative and overflow flags.

An operation is launched with a one-cycle start strobe. The clock edge that samples the strobe loads the result and flags into output registers and raises a done pulse for one cycle. The outputs then hold until the next start. Nibbles that are not valid decimal digits go through the same correction arithmetic, and no error is reported.

Top module: `bcd_byte_unit`

## Requirements
- R1: Only bits [7:0] of `dst_i` and `src_i` enter the arithmetic. `res_o[OP_W-1:8]` equals `dst_i[OP_W-1:8]` as sampled with the start strobe, and upper source bits have no effect on any output.
- R2: With `sub_i`=1, compute lo = dst[3:0] - src[3:0] - x_i as a signed value, and subtract 6 if lo > 9. Then compute t = lo + dst[7:4]*16 - src[7:4]*16, and subtract 0x60 if t > 0x99. `res_o[7:0]` = t[7:0].
- R3: With `sub_i`=0, compute lo = dst[3:0] + src[3:0] + x_i, and add 6 if lo > 9. Then compute t = lo + dst[7:4]*16 + src[7:4]*16, and add 0x60 if t > 0x99. `res_o[7:0]` = t[7:0].
- R4: `c_o` and `x_o` are both 1 exactly when t has any bit set above bit 7 (t < 0 or t > 255). They are always equal.
- R5: `z_o` = 0 when the result byte is nonzero. When the result byte is zero, `z_o` equals the `z_i` supplied with the strobe.
- R6: `n_o` equals bit 7 of the result byte.
- R7: `v_o` is bit 7 of (src XOR dst) AND (dst XOR result byte), using the low bytes. The same formula applies to add and subtract.
- R8: Results and flags load at the clock edge that samples `start_i`=1, and `done_o` is 1 for exactly the cycle after that edge. Without a strobe, `done_o` is 0 and every output holds its value.
- R9: While `rst_n` is low, every output is 0.
- R10: Nibble values 0xA to 0xF are processed by the same rules as R2 and R3, and the unit has no error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle operation strobe |
| sub_i | input | 1 | 1 = subtract source from destination, 0 = add |
| dst_i | input | OP_W | Destination operand |
| src_i | input | OP_W | Source operand |
| x_i | input | 1 | Current extend flag (carry/borrow in) |
| z_i | input | 1 | Current zero flag |
| res_o | output | OP_W | Destination with its low byte replaced |
| x_o | output | 1 | New extend flag |
| c_o | output | 1 | New carry flag |
| z_o | output | 1 | New zero flag |
| n_o | output | 1 | New negative flag |
| v_o | output | 1 | New overflow flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every result is due one clock edge after the strobe. This covers the low byte, the passed-through upper bits and all five flags, and `done_o` rises at that same edge. The bench drives inputs on falling edges and samples on the next falling edge, after exactly one register stage. It then changes the operands without a strobe and samples again one falling edge later. There it expects `done_o` low and every output unchanged.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIGIT_W = 4;
  localparam int BYTE_W  = 2 * DIGIT_W;
  // signed working width: covers -256 .. +613 with margin
  localparam int WORK_W  = BYTE_W + 4;

  typedef logic signed [WORK_W-1:0] work_t;
  typedef logic [DIGIT_W-1:0]       digit_t;
  typedef logic [BYTE_W-1:0]        byte_t;

  typedef struct packed {
    logic x;
    logic c;
    logic z;
    logic n;
    logic v;
  } ccr_t;

  localparam work_t DIGIT_LIMIT = work_t'(9);
  localparam work_t DIGIT_FIX   = work_t'(6);
  localparam work_t BYTE_LIMIT  = work_t'(8'h99);
  localparam work_t BYTE_FIX    = work_t'(8'h60);
endpackage

// File: rtl/bcd_low_digit.sv
module bcd_low_digit
  import bcd_pkg::*;
(
  input  digit_t dst_nib,
  input  digit_t src_nib,
  input  logic   sub,
  input  logic   ext_in,
  output work_t  lo_adj
);
  work_t d_w;
  work_t s_w;
  work_t cin_w;
  work_t raw;

  always_comb begin
    d_w   = work_t'(dst_nib);
    s_w   = work_t'(src_nib);
    cin_w = work_t'(ext_in);
    if (sub) begin
      raw = d_w - s_w - cin_w;
    end else begin
      raw = d_w + s_w + cin_w;
    end
    if (raw > DIGIT_LIMIT) begin
      lo_adj = sub ? (raw - DIGIT_FIX) : (raw + DIGIT_FIX);
    end else begin
      lo_adj = raw;
    end
  end
endmodule

// File: rtl/bcd_high_digit.sv
module bcd_high_digit
  import bcd_pkg::*;
(
  input  work_t  lo_adj,
  input  digit_t dst_nib,
  input  digit_t src_nib,
  input  logic   sub,
  output work_t  total
);
  work_t d_w;
  work_t s_w;
  work_t raw;

  always_comb begin
    // high digit kept in its weighted position
    d_w = work_t'({dst_nib, {DIGIT_W{1'b0}}});
    s_w = work_t'({src_nib, {DIGIT_W{1'b0}}});
    if (sub) begin
      raw = lo_adj + d_w - s_w;
    end else begin
      raw = lo_adj + d_w + s_w;
    end
    if (raw > BYTE_LIMIT) begin
      total = sub ? (raw - BYTE_FIX) : (raw + BYTE_FIX);
    end else begin
      total = raw;
    end
  end
endmodule

// File: rtl/bcd_flag_gen.sv
module bcd_flag_gen
  import bcd_pkg::*;
(
  input  work_t total,
  input  byte_t dst_b,
  input  byte_t src_b,
  input  logic  zero_in,
  output byte_t res_b,
  output ccr_t  flags
);
  logic carry;
  byte_t ovf_vec;

  always_comb begin
    res_b   = total[BYTE_W-1:0];
    carry   = |total[WORK_W-1:BYTE_W];
    ovf_vec = (src_b ^ dst_b) & (dst_b ^ res_b);
    flags.x = carry;
    flags.c = carry;
    flags.z = zero_in & (res_b == '0);
    flags.n = res_b[BYTE_W-1];
    flags.v = ovf_vec[BYTE_W-1];
  end
endmodule

// File: rtl/bcd_byte_unit.sv
module bcd_byte_unit
  import bcd_pkg::*;
#(
  parameter int OP_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            sub_i,
  input  logic [OP_W-1:0] dst_i,
  input  logic [OP_W-1:0] src_i,
  input  logic            x_i,
  input  logic            z_i,
  output logic [OP_W-1:0] res_o,
  output logic            x_o,
  output logic            c_o,
  output logic            z_o,
  output logic            n_o,
  output logic            v_o,
  output logic            done_o
);
  localparam int UPPER_W = OP_W - BYTE_W;

  work_t lo_adj;
  work_t total;
  byte_t res_b;
  ccr_t  flags_nx;

  logic [OP_W-1:0] res_q, res_d;
  ccr_t            ccr_q, ccr_d;
  logic            done_q, done_d;

  bcd_low_digit u_lo (
    .dst_nib (dst_i[DIGIT_W-1:0]),
    .src_nib (src_i[DIGIT_W-1:0]),
    .sub     (sub_i),
    .ext_in  (x_i),
    .lo_adj  (lo_adj)
  );

  bcd_high_digit u_hi (
    .lo_adj  (lo_adj),
    .dst_nib (dst_i[BYTE_W-1:DIGIT_W]),
    .src_nib (src_i[BYTE_W-1:DIGIT_W]),
    .sub     (sub_i),
    .total   (total)
  );

  bcd_flag_gen u_flg (
    .total   (total),
    .dst_b   (dst_i[BYTE_W-1:0]),
    .src_b   (src_i[BYTE_W-1:0]),
    .zero_in (z_i),
    .res_b   (res_b),
    .flags   (flags_nx)
  );

  // next-state
  always_comb begin
    res_d  = res_q;
    ccr_d  = ccr_q;
    done_d = start_i;
    if (start_i) begin
      ccr_d = flags_nx;
      if (UPPER_W > 0) begin
        res_d = {dst_i[OP_W-1:BYTE_W], res_b};
      end else begin
        res_d = OP_W'(res_b);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      ccr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      ccr_q  <= ccr_d;
      done_q <= done_d;
    end
  end

  assign res_o  = res_q;
  assign x_o    = ccr_q.x;
  assign c_o    = ccr_q.c;
  assign z_o    = ccr_q.z;
  assign n_o    = ccr_q.n;
  assign v_o    = ccr_q.v;
  assign done_o = done_q;
endmodule

// File: rtl/bcd_byte_unit_chk.sv
module bcd_byte_unit_chk #(
  parameter int OP_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [OP_W-1:0] dst_i,
  input logic [OP_W-1:0] src_i,
  input logic            z_i,
  input logic [OP_W-1:0] res_o,
  input logic            x_o,
  input logic            c_o,
  input logic            z_o,
  input logic            n_o,
  input logic            done_o
);
  // R8: strobe produces done on the next cycle
  a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  // R8: no strobe, no done and outputs hold
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!done_o && $stable(res_o) && $stable(z_o) && $stable(c_o)));
  // R4: extend mirrors carry
  a_r4_x_eq_c: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (x_o == c_o));
  // R6: negative equals result bit 7
  a_r6_neg_bit: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (n_o == res_o[7]));
  // R5: zero can never be set by the unit
  a_r5_z_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!z_o || $past(z_i)));
  // R5: nonzero byte clears zero
  a_r5_z_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && res_o[7:0] != 8'h00) |-> !z_o);
  // R1: upper destination bits pass through
  a_r1_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (res_o[OP_W-1:8] == $past(dst_i[OP_W-1:8])));
endmodule

bind bcd_byte_unit bcd_byte_unit_chk #(.OP_W(OP_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .dst_i   (dst_i),
  .src_i   (src_i),
  .z_i     (z_i),
  .res_o   (res_o),
  .x_o     (x_o),
  .c_o     (c_o),
  .z_o     (z_o),
  .n_o     (n_o),
  .done_o  (done_o)
);

// File: tb/test_bcd_byte_unit.sv
`timescale 1ns/1ps
module test_bcd_byte_unit;
  localparam int OP_W = 32;

  logic            clk;
  logic            rst_n;
  logic            start_i;
  logic            sub_i;
  logic [OP_W-1:0] dst_i;
  logic [OP_W-1:0] src_i;
  logic            x_i;
  logic            z_i;
  logic [OP_W-1:0] res_o;
  logic            x_o, c_o, z_o, n_o, v_o, done_o;

  int total_cnt = 0;
  int bad_cnt   = 0;
  bit finished  = 0;

  bcd_byte_unit #(.OP_W(OP_W)) i_bcd_byte_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i),
    .dst_i(dst_i), .src_i(src_i), .x_i(x_i), .z_i(z_i),
    .res_o(res_o), .x_o(x_o), .c_o(c_o), .z_o(z_o), .n_o(n_o),
    .v_o(v_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected {x,c,z,n,v,byte}
  function automatic logic [12:0] model(input bit sub, input logic [7:0] d,
                                        input logic [7:0] s, input bit x, input bit z);
    int di = int'(d);
    int si = int'(s);
    int xi = x ? 1 : 0;
    int lo;
    int t;
    logic [7:0] b;
    bit cy;
    logic [7:0] ov;
    if (sub) begin
      lo = (di % 16) - (si % 16) - xi;
      if (lo > 9) lo = lo - 6;
      t = lo + (di / 16) * 16 - (si / 16) * 16;
      if (t > 153) t = t - 96;
    end else begin
      lo = (di % 16) + (si % 16) + xi;
      if (lo > 9) lo = lo + 6;
      t = lo + (di / 16) * 16 + (si / 16) * 16;
      if (t > 153) t = t + 96;
    end
    b  = t[7:0];
    cy = (t < 0) || (t > 255);
    ov = (s ^ d) & (d ^ b);
    return {cy, cy, (z && b == 8'h00), b[7], ov[7], b};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total_cnt++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit sub, input logic [OP_W-1:0] d,
                        input logic [OP_W-1:0] s, input bit x, input bit z);
    logic [12:0] e;
    logic [OP_W-1:0] held;
    e = model(sub, d[7:0], s[7:0], x, z);
    @(negedge clk);
    start_i = 1'b1; sub_i = sub; dst_i = d; src_i = s; x_i = x; z_i = z;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b1, "R8 done", 32'(done_o), 32'd1);
    if (sub) check(res_o[7:0] == e[7:0], "R2 sub byte", 32'(res_o[7:0]), 32'(e[7:0]));
    else     check(res_o[7:0] == e[7:0], "R3 add byte", 32'(res_o[7:0]), 32'(e[7:0]));
    check(res_o[OP_W-1:8] == d[OP_W-1:8], "R1 upper", 32'(res_o), 32'(d));
    check(x_o == e[12] && c_o == e[11], "R4 x/c", {30'd0, x_o, c_o}, {30'd0, e[12:11]});
    check(z_o == e[10], "R5 z", 32'(z_o), 32'(e[10]));
    check(n_o == e[9], "R6 n", 32'(n_o), 32'(e[9]));
    check(v_o == e[8], "R7 v", 32'(v_o), 32'(e[8]));
    held = res_o;
    // change operands without a strobe: nothing must move (R8)
    dst_i = $urandom; src_i = $urandom; x_i = ~x; z_i = ~z; sub_i = ~sub;
    @(negedge clk);
    check(done_o == 1'b0 && res_o == held && z_o == e[10] && c_o == e[11],
          "R8 hold", 32'(res_o), 32'(held));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; sub_i = 1'b0; dst_i = '0; src_i = '0;
    x_i = 1'b0; z_i = 1'b0;
    repeat (3) @(negedge clk);
    check({res_o, x_o, c_o, z_o, n_o, v_o, done_o} == '0, "R9 reset",
          res_o, 32'd0);
    rst_n = 1'b1;

    // directed corner cases
    run_op(1'b0, 32'hABCD_0099, 32'h0000_0001, 1'b0, 1'b1); // R3 wrap to 00, carry, z kept
    run_op(1'b1, 32'h1234_0000, 32'h0000_0001, 1'b0, 1'b1); // R2 borrow -> FF
    run_op(1'b1, 32'h0000_0010, 32'h0000_0001, 1'b0, 1'b0); // R2 negative low digit
    run_op(1'b0, 32'h0000_0045, 32'h0000_0038, 1'b1, 1'b0); // R3 carry-in
    run_op(1'b0, 32'h0000_00FF, 32'h0000_00FF, 1'b1, 1'b1); // R10 invalid digits
    run_op(1'b1, 32'h0000_00AF, 32'h0000_00F0, 1'b1, 1'b1); // R10 invalid subtract
    run_op(1'b1, 32'h5555_0042, 32'hFFFF_0042, 1'b0, 1'b0); // R5 zero result, z_i=0
    run_op(1'b1, 32'h0000_0042, 32'h0000_0042, 1'b0, 1'b1); // R5 zero result, z_i=1
    run_op(1'b0, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1); // R5 nonzero clears
    // R1: upper source bits irrelevant
    run_op(1'b0, 32'h0000_0027, 32'hDEAD_BE15, 1'b0, 1'b0);

    // random mix with mostly valid BCD
    for (int i = 0; i < 400; i++) begin
      logic [OP_W-1:0] d, s;
      d = $urandom; s = $urandom;
      if (($urandom % 4) != 0) begin
        d[7:0] = {4'($urandom % 10), 4'($urandom % 10)};
        s[7:0] = {4'($urandom % 10), 4'($urandom % 10)};
      end
      run_op(1'($urandom), d, s, 1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total_cnt++;
      bad_cnt++;
      $display("FAIL watchdog R8 actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
      $finish;
    end
  end
endmodule